// File: doc/BRIEF.md
# Row-Buffered Multiplexed-Address DRAM Array

This block is a cycle-level model of a small dynamic memory: a grid of byte-wide supercells, ROWS by COLS (4 x 4 by default). A single narrow address bus carries a row index at one moment and a column index at another. A row-select strobe copies the whole addressed row into an internal row buffer. A column-select strobe then reads one supercell out of that buffer or writes one into it. The buffer goes back into the array when the row is closed or replaced. Because of this, repeated column accesses to the open row cost one cycle each, while a new row costs an activation delay first.

The model also ages its stored rows. A row that no operation has touched for RETAIN cycles loses its contents, which become zero. An internal refresh engine visits one row every REF_INT cycles in round-robin order and restores it. The engine only works while no row is open. A refresh that falls due while a row is open waits until the next idle cycle.

Read data comes out on a dedicated output port, together with a one-cycle valid pulse; there is no bidirectional bus. A column strobe that cannot be honoured does nothing to the memory and produces an error pulse instead.

Top module: `rowbuf_dram`

## Requirements
- R1: After reset, rdValid and protoErr are 0, no row is open (a column strobe is rejected), and every supercell reads 0x00.
- R2: A row strobe with row index r on addrIn opens row r. A later accepted column read with column index c on addrIn drives supercell (r,c) on rdData, with rdValid high for exactly the cycle after the strobe's clock edge.
- R3: An accepted column strobe with writeEn=1 replaces supercell c of the open row with wrData. A following read of that column returns the new byte, and the byte is still there after the row is closed and opened again.
- R4: After a row strobe sampled at edge k, a column strobe sampled before edge k+ROW_LAT is rejected. From edge k+ROW_LAT on, column strobes to the open row are accepted on every consecutive cycle.
- R5: A column write never produces an rdValid pulse, and rdValid is never high in the same cycle as protoErr.
- R6: A column strobe with no open row is ignored. protoErr pulses for one cycle after it, no rdValid follows, and no supercell changes.
- R7: A row strobe while a row is open first stores the buffer back into the old row. A row strobe naming the row that is already open keeps the buffer contents.
- R8: A refresh falls due every REF_INT cycles and restores one row, visiting the rows round-robin. It runs only on a cycle with no open row and no row strobe; a refresh that falls due while a row is open waits for the next idle cycle.
- R9: A row that no load, store-back or refresh touches for RETAIN cycles decays to all zeros. With the memory idle, refresh keeps every row intact indefinitely (requires RETAIN > ROWS*REF_INT).
- R10: Priority is row strobe, then closeRow, then column strobe. A column strobe in the same cycle as either of the others is rejected with protoErr. closeRow with no open row has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addrIn | input | AW | Multiplexed address: row index with rowStrobe, column index with colStrobe |
| rowStrobe | input | 1 | Open the addressed row into the row buffer |
| colStrobe | input | 1 | Access the addressed column of the open row |
| closeRow | input | 1 | Store the row buffer back and close the row |
| writeEn | input | 1 | With colStrobe: 1 = write wrData, 0 = read |
| wrData | input | DW | Byte to write into the row buffer |
| rdData | output | DW | Byte read from the row buffer |
| rdValid | output | 1 | One-cycle pulse marking rdData valid |
| protoErr | output | 1 | One-cycle pulse for a rejected column strobe |

## Verification
The bound checker watches protocol ordering on every cycle. It checks that rdValid only follows an unobstructed read, that writes never pulse rdValid, and that column strobes in the idle or activating state, or alongside a row strobe, produce an error. It also checks that refresh fires only in idle cycles and that an idle stretch never runs longer than REF_INT cycles without a refresh. The stored data itself can only be shown by the bench's scenarios: write-back on a row switch, the buffer kept on a same-row strobe, retention across a long idle stretch, and decay of an unrefreshed row while another row is held open.

// File: rtl/rowbuf_dram_pkg.sv
package rowbuf_dram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_OPEN = 2'd2
  } rowState_e;

  // strobes from control to datapath, one bit per action this cycle
  typedef struct packed {
    logic loadRow;    // copy array row into buffer
    logic writeBack;  // copy buffer into the open row
    logic colRead;    // buffer byte to rdData
    logic colWrite;   // wrData into buffer byte
    logic doRefresh;  // restore the row under the refresh pointer
    logic reject;     // column strobe refused
  } dpCmd_t;

endpackage

// File: rtl/rowbuf_dram_ctrl.sv
module rowbuf_dram_ctrl
  import rowbuf_dram_pkg::*;
#(
  parameter int ROWS    = 4,
  parameter int ROW_LAT = 2,
  parameter int REF_INT = 32,
  localparam int RW     = $clog2(ROWS),
  localparam int CW     = $clog2(ROW_LAT) + 1,
  localparam int TW     = $clog2(REF_INT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rowStrobe,
  input  logic          colStrobe,
  input  logic          closeRow,
  input  logic          writeEn,
  input  logic [RW-1:0] newRow,
  output dpCmd_t        cmd,
  output logic [RW-1:0] openRow,
  output logic [RW-1:0] refRow,
  output rowState_e     state
);

  logic [CW-1:0] actCnt;
  logic [TW-1:0] refTimer;
  logic          refPending;
  logic          refTick;
  logic          colOk;
  logic          rowHeld;

  assign rowHeld = (state != ST_IDLE);
  assign refTick = (refTimer == TW'(REF_INT - 1));
  assign colOk   = colStrobe && !rowStrobe && !closeRow && (state == ST_OPEN);

  always_comb begin
    cmd           = '0;
    cmd.loadRow   = rowStrobe;
    cmd.writeBack = (rowStrobe || closeRow) && rowHeld;
    cmd.colRead   = colOk && !writeEn;
    cmd.colWrite  = colOk && writeEn;
    cmd.reject    = colStrobe && !colOk;
    cmd.doRefresh = refPending && !rowHeld && !rowStrobe;
  end

  // row state machine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      actCnt  <= '0;
      openRow <= '0;
    end else if (rowStrobe) begin
      state   <= ST_ACT;
      actCnt  <= CW'(1);
      openRow <= newRow;
    end else if (closeRow && rowHeld) begin
      state <= ST_IDLE;
    end else if (state == ST_ACT) begin
      if (actCnt == CW'(ROW_LAT - 1)) state <= ST_OPEN;
      else                            actCnt <= actCnt + CW'(1);
    end
  end

  // refresh interval timer and round-robin pointer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refTimer   <= '0;
      refPending <= 1'b0;
      refRow     <= '0;
    end else begin
      refTimer   <= refTick ? '0 : refTimer + TW'(1);
      refPending <= (refPending && !cmd.doRefresh) || refTick;
      if (cmd.doRefresh)
        refRow <= (refRow == RW'(ROWS - 1)) ? '0 : refRow + RW'(1);
    end
  end

endmodule

// File: rtl/rowbuf_dram_dp.sv
module rowbuf_dram_dp
  import rowbuf_dram_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int DW     = 8,
  parameter int RETAIN = 256,
  localparam int RW    = $clog2(ROWS),
  localparam int CWID  = $clog2(COLS),
  localparam int AGW   = $clog2(RETAIN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dpCmd_t          cmd,
  input  logic [RW-1:0]   newRow,
  input  logic [RW-1:0]   openRow,
  input  logic [RW-1:0]   refRow,
  input  logic [CWID-1:0] colIdx,
  input  logic [DW-1:0]   wrData,
  output logic [DW-1:0]   rdData,
  output logic            rdValid,
  output logic            protoErr
);

  logic [DW-1:0]  cells  [ROWS][COLS];
  logic [DW-1:0]  rowBuf [COLS];
  logic [AGW-1:0] age    [ROWS];
  logic [ROWS-1:0] touched;
  logic           keepBuf;

  // a re-strobe of the row already in the buffer keeps the buffer
  assign keepBuf = cmd.writeBack && (newRow == openRow);

  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_touch
      assign touched[r] = (cmd.loadRow   && newRow  == RW'(r)) ||
                          (cmd.writeBack && openRow == RW'(r)) ||
                          (cmd.doRefresh && refRow  == RW'(r));
    end
  endgenerate

  // charge age per row; refresh rewrites the row unchanged, so only age resets
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) age[r] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (touched[r])                   age[r] <= '0;
        else if (age[r] != AGW'(RETAIN))  age[r] <= age[r] + AGW'(1);
      end
    end
  end

  // storage array: decay, then store-back overrides
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) cells[r][c] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++)
        if (age[r] == AGW'(RETAIN) && !touched[r])
          for (int c = 0; c < COLS; c++) cells[r][c] <= '0;
      if (cmd.writeBack)
        for (int c = 0; c < COLS; c++) cells[openRow][c] <= rowBuf[c];
    end
  end

  // row buffer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < COLS; c++) rowBuf[c] <= '0;
    end else if (cmd.loadRow) begin
      if (!keepBuf)
        for (int c = 0; c < COLS; c++) rowBuf[c] <= cells[newRow][c];
    end else if (cmd.colWrite) begin
      rowBuf[colIdx] <= wrData;
    end
  end

  // read port and pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData   <= '0;
      rdValid  <= 1'b0;
      protoErr <= 1'b0;
    end else begin
      rdValid  <= cmd.colRead;
      protoErr <= cmd.reject;
      if (cmd.colRead) rdData <= rowBuf[colIdx];
    end
  end

endmodule

// File: rtl/rowbuf_dram.sv
module rowbuf_dram
  import rowbuf_dram_pkg::*;
#(
  parameter int ROWS    = 4,
  parameter int COLS    = 4,
  parameter int DW      = 8,
  parameter int ROW_LAT = 2,
  parameter int REF_INT = 32,
  parameter int RETAIN  = 256,
  localparam int RW     = $clog2(ROWS),
  localparam int CWID   = $clog2(COLS),
  localparam int AW     = (RW > CWID) ? RW : CWID
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addrIn,
  input  logic          rowStrobe,
  input  logic          colStrobe,
  input  logic          closeRow,
  input  logic          writeEn,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic          protoErr
);

  dpCmd_t        dpCmd;
  rowState_e     ctrlState;
  logic [RW-1:0] openRow;
  logic [RW-1:0] refRow;

  rowbuf_dram_ctrl #(
    .ROWS(ROWS), .ROW_LAT(ROW_LAT), .REF_INT(REF_INT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rowStrobe(rowStrobe), .colStrobe(colStrobe),
    .closeRow(closeRow), .writeEn(writeEn),
    .newRow(addrIn[RW-1:0]),
    .cmd(dpCmd), .openRow(openRow), .refRow(refRow), .state(ctrlState)
  );

  rowbuf_dram_dp #(
    .ROWS(ROWS), .COLS(COLS), .DW(DW), .RETAIN(RETAIN)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(dpCmd),
    .newRow(addrIn[RW-1:0]), .openRow(openRow), .refRow(refRow),
    .colIdx(addrIn[CWID-1:0]), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .protoErr(protoErr)
  );

endmodule

// File: rtl/rowbuf_dram_chk.sv
module rowbuf_dram_chk
  import rowbuf_dram_pkg::*;
#(
  parameter int REF_INT = 32,
  localparam int SW     = $clog2(REF_INT + 2) + 1
) (
  input logic      clk,
  input logic      rst_n,
  input logic      rowStrobe,
  input logic      colStrobe,
  input logic      closeRow,
  input logic      writeEn,
  input logic      rdValid,
  input logic      protoErr,
  input rowState_e state,
  input logic      refreshNow
);

  // idle cycles since the last refresh
  logic [SW-1:0] sinceRef;
  always_ff @(posedge clk) begin
    if (!rst_n || refreshNow || state != ST_IDLE || rowStrobe) sinceRef <= '0;
    else if (sinceRef != {SW{1'b1}})                             sinceRef <= sinceRef + SW'(1);
  end

  // R5: a valid pulse only follows an unobstructed column read
  a_r5_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> $past(colStrobe && !writeEn && !rowStrobe && !closeRow));

  // R5: writes give no valid pulse
  a_r5_no_valid_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (colStrobe && writeEn) |=> !rdValid);

  // R5: valid and error are exclusive
  a_r5_valid_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdValid && protoErr));

  // R6: column strobe with no open row is rejected
  a_r6_closed_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && colStrobe) |=> (protoErr && !rdValid));

  // R4: column strobe during activation is rejected
  a_r4_act_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACT && colStrobe) |=> protoErr);

  // R10: row strobe wins over column strobe
  a_r10_row_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rowStrobe && colStrobe) |=> protoErr);

  // R8: refresh only in idle cycles without a row strobe
  a_r8_refresh_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    refreshNow |-> (state == ST_IDLE && !rowStrobe));

  // R8: idle stretches never outlast the refresh interval
  a_r8_refresh_interval: assert property (@(posedge clk) disable iff (!rst_n)
    sinceRef <= SW'(REF_INT));

endmodule

bind rowbuf_dram rowbuf_dram_chk #(.REF_INT(REF_INT)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rowStrobe(rowStrobe), .colStrobe(colStrobe),
  .closeRow(closeRow), .writeEn(writeEn),
  .rdValid(rdValid), .protoErr(protoErr),
  .state(ctrlState), .refreshNow(dpCmd.doRefresh)
);

// File: tb/rowbuf_dram_tb.sv
module rowbuf_dram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_LAT    = 2;
  localparam int REF_INT    = 32;
  localparam int RETAIN     = 256;

  localparam logic [2:0] OP_IDLE     = 3'd0;
  localparam logic [2:0] OP_ROW      = 3'd1;
  localparam logic [2:0] OP_RD       = 3'd2;
  localparam logic [2:0] OP_WR       = 3'd3;
  localparam logic [2:0] OP_CLOSE    = 3'd4;
  localparam logic [2:0] OP_ROWCOL   = 3'd5;
  localparam logic [2:0] OP_CLOSECOL = 3'd6;

  typedef struct packed {
    logic [2:0] op;
    logic [1:0] addr;
    logic [7:0] wdat;
    logic       expV;
    logic [7:0] expD;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{OP_ROW,   2'd0, 8'h00, 1'b0, 8'h00},  // R2 open row 0
    '{OP_IDLE,  2'd0, 8'h00, 1'b0, 8'h00},  // activation gap
    '{OP_WR,    2'd0, 8'h11, 1'b0, 8'h00},  // R3
    '{OP_WR,    2'd1, 8'h22, 1'b0, 8'h00},
    '{OP_WR,    2'd2, 8'h33, 1'b0, 8'h00},
    '{OP_WR,    2'd3, 8'h44, 1'b0, 8'h00},
    '{OP_RD,    2'd2, 8'h00, 1'b1, 8'h33},  // R3 read back
    '{OP_RD,    2'd0, 8'h00, 1'b1, 8'h11},
    '{OP_CLOSE, 2'd0, 8'h00, 1'b0, 8'h00},
    '{OP_ROW,   2'd1, 8'h00, 1'b0, 8'h00},
    '{OP_IDLE,  2'd0, 8'h00, 1'b0, 8'h00},
    '{OP_WR,    2'd1, 8'hA5, 1'b0, 8'h00},
    '{OP_RD,    2'd1, 8'h00, 1'b1, 8'hA5},
    '{OP_RD,    2'd3, 8'h00, 1'b1, 8'h00},  // R1 reset contents
    '{OP_ROW,   2'd0, 8'h00, 1'b0, 8'h00},  // R7 switch rows
    '{OP_IDLE,  2'd0, 8'h00, 1'b0, 8'h00},
    '{OP_RD,    2'd3, 8'h00, 1'b1, 8'h44},  // R3 survived close
    '{OP_ROW,   2'd1, 8'h00, 1'b0, 8'h00},
    '{OP_IDLE,  2'd0, 8'h00, 1'b0, 8'h00},
    '{OP_RD,    2'd1, 8'h00, 1'b1, 8'hA5},  // R7 stored back on switch
    '{OP_CLOSE, 2'd0, 8'h00, 1'b0, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addrIn;
  logic       rowStrobe, colStrobe, closeRow, writeEn;
  logic [7:0] wrData, rdData;
  logic       rdValid, protoErr;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rowbuf_dram #(
    .ROWS(4), .COLS(4), .DW(8),
    .ROW_LAT(ROW_LAT), .REF_INT(REF_INT), .RETAIN(RETAIN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn),
    .rowStrobe(rowStrobe), .colStrobe(colStrobe),
    .closeRow(closeRow), .writeEn(writeEn), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .protoErr(protoErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next one with outputs settled
  task automatic step(input logic [2:0] op, input logic [1:0] a, input logic [7:0] d);
    rowStrobe = (op == OP_ROW) || (op == OP_ROWCOL);
    colStrobe = (op == OP_RD) || (op == OP_WR) || (op == OP_ROWCOL) || (op == OP_CLOSECOL);
    writeEn   = (op == OP_WR);
    closeRow  = (op == OP_CLOSE) || (op == OP_CLOSECOL);
    addrIn    = a;
    wrData    = d;
    @(negedge clk);
    rowStrobe = 1'b0; colStrobe = 1'b0; writeEn = 1'b0; closeRow = 1'b0;
    addrIn = '0; wrData = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(OP_IDLE, 2'd0, 8'h00);
  endtask

  task automatic expectRead(input string req, input logic [7:0] exp);
    check(rdValid === 1'b1, req, rdValid, 1);
    check(protoErr === 1'b0, req, protoErr, 0);
    check(rdData === exp, req, rdData, exp);
  endtask

  task automatic expectReject(input string req);
    check(protoErr === 1'b1, req, protoErr, 1);
    check(rdValid === 1'b0, req, rdValid, 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    finishRun();
  end

  initial begin
    rst_n = 1'b0;
    rowStrobe = 1'b0; colStrobe = 1'b0; closeRow = 1'b0; writeEn = 1'b0;
    addrIn = '0; wrData = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdValid === 1'b0, "R1 rdValid", rdValid, 0);
    check(protoErr === 1'b0, "R1 protoErr", protoErr, 0);
    rst_n = 1'b1;
    step(OP_RD, 2'd0, 8'h00);
    expectReject("R1 no row open after reset");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].op, VECS[i].addr, VECS[i].wdat);
      check(rdValid === VECS[i].expV, $sformatf("R2/R5 vec%0d rdValid", i), rdValid, VECS[i].expV);
      check(protoErr === 1'b0, $sformatf("R2 vec%0d protoErr", i), protoErr, 0);
      if (VECS[i].expV)
        check(rdData === VECS[i].expD, $sformatf("R2/R3 vec%0d rdData", i), rdData, VECS[i].expD);
    end

    // R6: write with no open row is ignored, error pulse lasts one cycle
    step(OP_WR, 2'd1, 8'hFF);
    expectReject("R6 write with row closed");
    step(OP_IDLE, 2'd0, 8'h00);
    check(protoErr === 1'b0, "R6 single error pulse", protoErr, 0);

    // R4: column too early after row strobe, then back-to-back hits
    step(OP_ROW, 2'd2, 8'h00);
    step(OP_RD, 2'd0, 8'h00);
    expectReject("R4 column inside activation");
    step(OP_RD, 2'd0, 8'h00);
    expectRead("R4 first accepted column", 8'h00);
    step(OP_RD, 2'd1, 8'h00);
    expectRead("R4 back-to-back hit", 8'h00);

    // R7: same-row re-strobe keeps the buffer
    step(OP_WR, 2'd0, 8'h5A);
    check(rdValid === 1'b0, "R5 write gives no valid", rdValid, 0);
    step(OP_ROW, 2'd2, 8'h00);
    step(OP_IDLE, 2'd0, 8'h00);
    step(OP_RD, 2'd0, 8'h00);
    expectRead("R7 same-row re-strobe", 8'h5A);

    // R10: priority
    step(OP_ROWCOL, 2'd2, 8'h00);
    expectReject("R10 row strobe beats column");
    step(OP_IDLE, 2'd0, 8'h00);
    step(OP_CLOSECOL, 2'd0, 8'h00);
    expectReject("R10 close beats column");
    step(OP_RD, 2'd0, 8'h00);
    expectReject("R10 row closed by close");

    // R9: long idle stretch, refresh keeps data; R6 write had no effect
    idle(700);
    step(OP_ROW, 2'd1, 8'h00);
    step(OP_IDLE, 2'd0, 8'h00);
    step(OP_RD, 2'd1, 8'h00);
    expectRead("R9/R6 row1 col1 kept", 8'hA5);
    step(OP_ROW, 2'd0, 8'h00);
    step(OP_IDLE, 2'd0, 8'h00);
    step(OP_RD, 2'd3, 8'h00);
    expectRead("R9 row0 col3 kept", 8'h44);
    step(OP_CLOSE, 2'd0, 8'h00);

    // R8: refresh deferred while a row stays open, so another row decays
    step(OP_ROW, 2'd0, 8'h00);
    idle(400);
    step(OP_CLOSE, 2'd0, 8'h00);
    step(OP_ROW, 2'd1, 8'h00);
    step(OP_IDLE, 2'd0, 8'h00);
    step(OP_RD, 2'd1, 8'h00);
    expectRead("R8/R9 unrefreshed row decayed", 8'h00);
    step(OP_ROW, 2'd0, 8'h00);
    step(OP_IDLE, 2'd0, 8'h00);
    step(OP_RD, 2'd3, 8'h00);
    expectRead("R8 held row stored back intact", 8'h44);
    step(OP_CLOSE, 2'd0, 8'h00);

    finishRun();
  end

endmodule